// File: doc/BRIEF.md
# Base-Delta Cache Line Compressor

This block squeezes one 32-byte cache line into a shorter form by writing most of its elements as small signed offsets. Every candidate layout runs at once. Each layout splits the line into equal elements and keeps the first element as an explicit base. Each element is stored as a narrow delta, taken either against that base or against an implicit base of zero. A separate test looks for an all-zero line and another for a line that repeats one 8-byte value. The block picks the shortest layout that holds every element and registers it. The result is a format code, the packed bytes, their byte count, and one selector bit per element that records which base the element uses.

The same block also holds the reverse path. A captured format code, packed bytes and selector bits go in, and the original line comes out. The rebuild adds each sign-extended delta to the base that its selector bit names, with every element handled in parallel. Both directions have one cycle of latency and are launched by their own valid strobe.

Top module: `bdc_line_codec`

## Requirements
- R1: A line presented with `inValid` high appears on the compressor outputs at the next rising edge, and `outValid` is high for exactly that one cycle. The same one-cycle timing links `decValid` to `decLine` and `decOutValid`.
- R2: Format codes and their byte counts: 0 zero line (1), 1 repeated 8-byte value (8), 2 base8/delta1 (12), 3 base8/delta2 (16), 4 base8/delta4 (24), 5 base4/delta1 (12), 6 base4/delta2 (20), 7 base2/delta1 (18), 15 uncompressed (32). Elements are little-endian slices of `lineIn`, and element 0 is the least significant.
- R3: An all-zero line gives code 0, size 1, all-zero packed bytes and all-zero selector bits.
- R4: A line made of one 8-byte value repeated four times, and not all zero, gives code 1, size 8, with that value in packed bytes 0..7 and zeros above.
- R5: An element fits a D-byte delta when its value read as a signed D-byte number reproduces it. The delta against zero is tested first, and if it fits the selector bit is 0. Otherwise the element's difference from element 0 must fit, and the selector bit is 1. Selector bit i belongs to element i, and bits above the element count are 0.
- R6: For a base/delta layout, packed bytes 0..B-1 hold element 0, the delta of element i sits at byte B + i*D, and every byte at or above the reported size is zero.
- R7: Among the layouts in which every element fits, the smallest size wins. On equal sizes the lower code wins, so a line that fits both base8/delta1 and base4/delta1 gives code 2.
- R8: When no layout fits, the output is code 15, size 32, packed bytes equal to the input line, and all selector bits 0.
- R9: Feeding any compressor output (code, packed bytes, selector bits) back to the rebuild port reproduces the original line exactly.
- R10: While `rstN` is low, every output is zero.
- R11: While `inValid` is low, the compressor outputs keep their last value whatever `lineIn` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Capture `lineIn` for compression this cycle |
| lineIn | input | 256 | Uncompressed line, element 0 in the low bits |
| outValid | output | 1 | Compressor outputs were updated at the last edge |
| compFlag | output | 4 | Chosen format code |
| compSize | output | 6 | Byte count of the chosen form |
| compData | output | 256 | Packed bytes, zero-filled above the size |
| baseSel | output | 16 | Per-element base selector bits |
| decValid | input | 1 | Capture rebuild inputs this cycle |
| decFlag | input | 4 | Format code of the packed line |
| decData | input | 256 | Packed bytes to rebuild |
| decSel | input | 16 | Selector bits of the packed line |
| decOutValid | output | 1 | `decLine` was updated at the last edge |
| decLine | output | 256 | Rebuilt line |

## Verification
A wrong fit test or a wrong selector choice inside a layout unit shows up one cycle after capture in one of two ways: a code that differs from the smallest fitting layout, or a round trip that returns a different line. Both are checked on lines built so that exactly one family of layouts fits. A fault in the selection order shows up on the tie line, where two 12-byte layouts both fit. A packing offset error shows up as misplaced delta bytes, or as nonzero bytes beyond the reported size, in the same output cycle.

// File: rtl/bdc_pkg.sv
`timescale 1ns/1ps
package bdc_pkg;
  localparam int unsigned LINE_BYTES = 32;
  localparam int unsigned LINE_W     = LINE_BYTES * 8;
  localparam int unsigned WIDE_BYTES = 8;
  localparam int unsigned WIDE_W     = WIDE_BYTES * 8;
  localparam int unsigned NUM_WIDE   = LINE_BYTES / WIDE_BYTES;
  localparam int unsigned MAX_ELEMS  = LINE_BYTES / 2;
  localparam int unsigned SIZE_W     = $clog2(LINE_BYTES + 1);
  localparam int unsigned FLAG_W     = 4;
  localparam int unsigned NUM_CAND   = 6;
  localparam int unsigned CAND_FLAG0 = 2;
  localparam int unsigned ZERO_SIZE  = 1;

  // base and delta byte widths, listed in code order starting at CAND_FLAG0
  localparam int unsigned CAND_BASE  [NUM_CAND] = '{8, 8, 8, 4, 4, 2};
  localparam int unsigned CAND_DELTA [NUM_CAND] = '{1, 2, 4, 1, 2, 1};

  typedef enum logic [FLAG_W-1:0] {
    ENC_ZERO = 4'd0,
    ENC_REP  = 4'd1,
    ENC_B8D1 = 4'd2,
    ENC_B8D2 = 4'd3,
    ENC_B8D4 = 4'd4,
    ENC_B4D1 = 4'd5,
    ENC_B4D2 = 4'd6,
    ENC_B2D1 = 4'd7,
    ENC_RAW  = 4'd15
  } enc_e;

  typedef struct packed {
    logic capComp;
    logic capDec;
  } strobe_t;

  function automatic int unsigned cand_size(int unsigned c);
    return CAND_BASE[c] + (LINE_BYTES / CAND_BASE[c]) * CAND_DELTA[c];
  endfunction
endpackage

// File: rtl/bdc_delta_cand.sv
`timescale 1ns/1ps
module bdc_delta_cand #(
  parameter int unsigned LINE_BYTES  = 32,
  parameter int unsigned BASE_BYTES  = 8,
  parameter int unsigned DELTA_BYTES = 1
) (
  input  logic [LINE_BYTES*8-1:0] lineIn,
  output logic                    fitAll,
  output logic [(BASE_BYTES + (LINE_BYTES/BASE_BYTES)*DELTA_BYTES)*8-1:0] packedOut,
  output logic [LINE_BYTES/BASE_BYTES-1:0] selOut
);
  localparam int unsigned ELEMS = LINE_BYTES / BASE_BYTES;
  localparam int unsigned BW    = BASE_BYTES * 8;
  localparam int unsigned DW    = DELTA_BYTES * 8;

  logic [BW-1:0]    baseVal;
  logic [ELEMS-1:0] fitZero;
  logic [ELEMS-1:0] fitBase;
  logic [DW-1:0]    deltaVal [ELEMS];

  assign baseVal = lineIn[BW-1:0];

  for (genvar i = 0; i < ELEMS; i++) begin : g_elem
    logic [BW-1:0] elem;
    logic [BW-1:0] diff;
    assign elem = lineIn[i*BW +: BW];
    assign diff = elem - baseVal;
    // signed fit: everything from the delta sign bit upward is one value
    assign fitZero[i] = (&elem[BW-1:DW-1]) || !(|elem[BW-1:DW-1]);
    assign fitBase[i] = (&diff[BW-1:DW-1]) || !(|diff[BW-1:DW-1]);
    assign deltaVal[i] = fitZero[i] ? elem[DW-1:0] : diff[DW-1:0];
  end

  assign fitAll = &(fitZero | fitBase);
  assign selOut = ~fitZero;

  always_comb begin
    packedOut = '0;
    packedOut[BW-1:0] = baseVal;
    for (int i = 0; i < ELEMS; i++) begin
      packedOut[BW + i*DW +: DW] = deltaVal[i];
    end
  end
endmodule

// File: rtl/bdc_delta_expand.sv
`timescale 1ns/1ps
module bdc_delta_expand #(
  parameter int unsigned LINE_BYTES  = 32,
  parameter int unsigned BASE_BYTES  = 8,
  parameter int unsigned DELTA_BYTES = 1
) (
  input  logic [(BASE_BYTES + (LINE_BYTES/BASE_BYTES)*DELTA_BYTES)*8-1:0] packedIn,
  input  logic [LINE_BYTES/BASE_BYTES-1:0] selIn,
  output logic [LINE_BYTES*8-1:0] lineOut
);
  localparam int unsigned ELEMS = LINE_BYTES / BASE_BYTES;
  localparam int unsigned BW    = BASE_BYTES * 8;
  localparam int unsigned DW    = DELTA_BYTES * 8;

  logic [BW-1:0] baseVal;
  assign baseVal = packedIn[BW-1:0];

  for (genvar i = 0; i < ELEMS; i++) begin : g_elem
    logic [DW-1:0] delta;
    logic [BW-1:0] wide;
    assign delta = packedIn[BW + i*DW +: DW];
    assign wide  = {{(BW-DW){delta[DW-1]}}, delta};
    assign lineOut[i*BW +: BW] = selIn[i] ? (baseVal + wide) : wide;
  end
endmodule

// File: rtl/bdc_ctrl.sv
`timescale 1ns/1ps
module bdc_ctrl
  import bdc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    decValid,
  output strobe_t stb,
  output logic    outValid,
  output logic    decOutValid
);
  assign stb = '{capComp: inValid, capDec: decValid};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      decOutValid <= 1'b0;
    end else begin
      outValid    <= inValid;
      decOutValid <= decValid;
    end
  end
endmodule

// File: rtl/bdc_datapath.sv
`timescale 1ns/1ps
module bdc_datapath
  import bdc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [LINE_W-1:0]    lineIn,
  input  logic [FLAG_W-1:0]    decFlag,
  input  logic [LINE_W-1:0]    decData,
  input  logic [MAX_ELEMS-1:0] decSel,
  output logic [FLAG_W-1:0]    compFlag,
  output logic [SIZE_W-1:0]    compSize,
  output logic [LINE_W-1:0]    compData,
  output logic [MAX_ELEMS-1:0] baseSel,
  output logic [LINE_W-1:0]    decLine
);
  logic [NUM_CAND-1:0]  candOk;
  logic [LINE_W-1:0]    candData [NUM_CAND];
  logic [MAX_ELEMS-1:0] candSel  [NUM_CAND];
  logic [LINE_W-1:0]    expLine  [NUM_CAND];

  for (genvar c = 0; c < NUM_CAND; c++) begin : g_cand
    localparam int unsigned BB = CAND_BASE[c];
    localparam int unsigned DB = CAND_DELTA[c];
    localparam int unsigned NE = LINE_BYTES / BB;
    localparam int unsigned UW = (BB + NE*DB) * 8;
    logic [UW-1:0] packC;
    logic [NE-1:0] selC;

    bdc_delta_cand #(
      .LINE_BYTES (LINE_BYTES),
      .BASE_BYTES (BB),
      .DELTA_BYTES(DB)
    ) cand_i (
      .lineIn   (lineIn),
      .fitAll   (candOk[c]),
      .packedOut(packC),
      .selOut   (selC)
    );

    assign candData[c] = LINE_W'(packC);
    assign candSel[c]  = MAX_ELEMS'(selC);

    bdc_delta_expand #(
      .LINE_BYTES (LINE_BYTES),
      .BASE_BYTES (BB),
      .DELTA_BYTES(DB)
    ) exp_i (
      .packedIn(decData[UW-1:0]),
      .selIn   (decSel[NE-1:0]),
      .lineOut (expLine[c])
    );
  end

  // whole-line shape tests
  logic [NUM_WIDE-1:0] chunkEq;
  logic isZero;
  logic isRep;
  for (genvar k = 0; k < NUM_WIDE; k++) begin : g_chunk
    assign chunkEq[k] = (lineIn[k*WIDE_W +: WIDE_W] == lineIn[WIDE_W-1:0]);
  end
  assign isZero = (lineIn == '0);
  assign isRep  = &chunkEq;

  // pick the shortest fitting form; strict compare in code order breaks ties low
  logic [FLAG_W-1:0]    pickFlag;
  logic [SIZE_W-1:0]    pickSize;
  logic [LINE_W-1:0]    pickData;
  logic [MAX_ELEMS-1:0] pickSel;

  always_comb begin
    pickFlag = ENC_RAW;
    pickSize = SIZE_W'(LINE_BYTES);
    pickData = lineIn;
    pickSel  = '0;
    if (isZero && SIZE_W'(ZERO_SIZE) < pickSize) begin
      pickFlag = ENC_ZERO;
      pickSize = SIZE_W'(ZERO_SIZE);
      pickData = '0;
    end
    if (isRep && SIZE_W'(WIDE_BYTES) < pickSize) begin
      pickFlag = ENC_REP;
      pickSize = SIZE_W'(WIDE_BYTES);
      pickData = LINE_W'(lineIn[WIDE_W-1:0]);
    end
    for (int unsigned c = 0; c < NUM_CAND; c++) begin
      if (candOk[c] && SIZE_W'(cand_size(c)) < pickSize) begin
        pickFlag = FLAG_W'(CAND_FLAG0 + c);
        pickSize = SIZE_W'(cand_size(c));
        pickData = candData[c];
        pickSel  = candSel[c];
      end
    end
  end

  // rebuild mux
  logic [LINE_W-1:0] rebuilt;
  always_comb begin
    rebuilt = '0;
    if (decFlag == ENC_REP) begin
      rebuilt = {NUM_WIDE{decData[WIDE_W-1:0]}};
    end else if (decFlag == ENC_RAW) begin
      rebuilt = decData;
    end
    for (int unsigned c = 0; c < NUM_CAND; c++) begin
      if (decFlag == FLAG_W'(CAND_FLAG0 + c)) begin
        rebuilt = expLine[c];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      compFlag <= '0;
      compSize <= '0;
      compData <= '0;
      baseSel  <= '0;
      decLine  <= '0;
    end else begin
      if (stb.capComp) begin
        compFlag <= pickFlag;
        compSize <= pickSize;
        compData <= pickData;
        baseSel  <= pickSel;
      end
      if (stb.capDec) begin
        decLine <= rebuilt;
      end
    end
  end
endmodule

// File: rtl/bdc_line_codec.sv
`timescale 1ns/1ps
module bdc_line_codec
  import bdc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [LINE_W-1:0]    lineIn,
  output logic                 outValid,
  output logic [FLAG_W-1:0]    compFlag,
  output logic [SIZE_W-1:0]    compSize,
  output logic [LINE_W-1:0]    compData,
  output logic [MAX_ELEMS-1:0] baseSel,
  input  logic                 decValid,
  input  logic [FLAG_W-1:0]    decFlag,
  input  logic [LINE_W-1:0]    decData,
  input  logic [MAX_ELEMS-1:0] decSel,
  output logic                 decOutValid,
  output logic [LINE_W-1:0]    decLine
);
  strobe_t stb;

  bdc_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .decValid   (decValid),
    .stb        (stb),
    .outValid   (outValid),
    .decOutValid(decOutValid)
  );

  bdc_datapath dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .lineIn  (lineIn),
    .decFlag (decFlag),
    .decData (decData),
    .decSel  (decSel),
    .compFlag(compFlag),
    .compSize(compSize),
    .compData(compData),
    .baseSel (baseSel),
    .decLine (decLine)
  );
endmodule

// File: rtl/bdc_line_codec_chk.sv
`timescale 1ns/1ps
module bdc_line_codec_chk (
  input logic         clk,
  input logic         rstN,
  input logic         inValid,
  input logic         outValid,
  input logic [3:0]   compFlag,
  input logic [5:0]   compSize,
  input logic [255:0] compData,
  input logic [15:0]  baseSel,
  input logic         decValid,
  input logic         decOutValid
);
  function automatic logic [5:0] size_of(logic [3:0] f);
    case (f)
      4'd0:    return 6'd1;
      4'd1:    return 6'd8;
      4'd2:    return 6'd12;
      4'd3:    return 6'd16;
      4'd4:    return 6'd24;
      4'd5:    return 6'd12;
      4'd6:    return 6'd20;
      4'd7:    return 6'd18;
      4'd15:   return 6'd32;
      default: return 6'd0;
    endcase
  endfunction

  p_out_valid_r1: assert property (@(posedge clk) disable iff (!rstN)
    outValid == $past(inValid));

  p_dec_valid_r1: assert property (@(posedge clk) disable iff (!rstN)
    decOutValid == $past(decValid));

  p_flag_size_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (size_of(compFlag) != 6'd0) && (compSize == size_of(compFlag)));

  p_zero_form_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && compFlag == 4'd0) |-> (compData == '0) && (baseSel == '0));

  p_tail_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((compData >> (32'(compSize) * 8)) == '0));

  p_raw_form_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && compFlag == 4'd15) |-> (compSize == 6'd32) && (baseSel == '0));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !$past(inValid) |-> $stable(compFlag) && $stable(compSize)
                        && $stable(compData) && $stable(baseSel));
endmodule

bind bdc_line_codec bdc_line_codec_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .outValid   (outValid),
  .compFlag   (compFlag),
  .compSize   (compSize),
  .compData   (compData),
  .baseSel    (baseSel),
  .decValid   (decValid),
  .decOutValid(decOutValid)
);

// File: tb/bdc_line_codec_tb_top.sv
`timescale 1ns/1ps
module bdc_line_codec_tb_top;
  localparam int NVEC = 12;

  localparam logic [255:0] VEC_LINE [NVEC] = '{
    256'h0,
    256'h0123456789ABCDEF_0123456789ABCDEF_0123456789ABCDEF_0123456789ABCDEF,
    256'hC04039F8_C04039F0_C04039E8_C04039E0_C04039D8_C04039D0_C04039C8_C04039C0,
    256'h00000007_00000006_00000005_00000004_00000003_00000002_00000001_00000000,
    256'h00007FFF12345978_00007FFF12345878_00007FFF12345778_00007FFF12345678,
    256'hFFFFFFFFFFFFFF80_0000000000000003_112233445566778D_1122334455667788,
    256'h0000000000000003_0000000000000002_0000000000000001_0000000000000000,
    256'h000000007FFFFFFF_AAA9FFFFFFFF0000_AAAA000012345678_AAAA000000000000,
    256'h40000E00_40000C00_40000A00_40000800_40000600_40000400_40000200_40000000,
    256'h1243_1242_1241_1240_123F_123E_123D_123C_123B_123A_1239_1238_1237_1236_1235_1234,
    256'h0123456789ABCDEF_FEDCBA9876543210_0F1E2D3C4B5A6978_8796A5B4C3D2E1F0,
    {256{1'b1}}
  };
  localparam logic [3:0] VEC_FLAG [NVEC] = '{4'd0, 4'd1, 4'd5, 4'd5, 4'd3, 4'd2,
                                             4'd2, 4'd4, 4'd6, 4'd7, 4'd15, 4'd1};
  localparam logic [5:0] VEC_SIZE [NVEC] = '{6'd1, 6'd8, 6'd12, 6'd12, 6'd16, 6'd12,
                                             6'd12, 6'd24, 6'd20, 6'd18, 6'd32, 6'd8};

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [255:0] lineIn = '0;
  logic         outValid;
  logic [3:0]   compFlag;
  logic [5:0]   compSize;
  logic [255:0] compData;
  logic [15:0]  baseSel;
  logic         decValid = 1'b0;
  logic [3:0]   decFlag = '0;
  logic [255:0] decData = '0;
  logic [15:0]  decSel = '0;
  logic         decOutValid;
  logic [255:0] decLine;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  bdc_line_codec dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .lineIn(lineIn),
    .outValid(outValid), .compFlag(compFlag), .compSize(compSize),
    .compData(compData), .baseSel(baseSel), .decValid(decValid),
    .decFlag(decFlag), .decData(decData), .decSel(decSel),
    .decOutValid(decOutValid), .decLine(decLine)
  );

  task automatic check(input bit ok, input string req,
                       input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compress(input logic [255:0] l);
    @(negedge clk);
    inValid = 1'b1;
    lineIn  = l;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic rebuild();
    @(negedge clk);
    decValid = 1'b1;
    decFlag  = compFlag;
    decData  = compData;
    decSel   = baseSel;
    @(negedge clk);
    decValid = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: outputs are zero while reset is held
    check(outValid == 1'b0 && decOutValid == 1'b0 && compFlag == 4'd0 &&
          compSize == 6'd0 && baseSel == 16'd0, "R10 reset ctrl",
          {outValid, decOutValid, compFlag, compSize, baseSel}, '0);
    check(compData == '0 && decLine == '0, "R10 reset data", compData | decLine, '0);
    rstN = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      compress(VEC_LINE[v]);
      check(outValid == 1'b1, "R1 outValid after capture", 256'(outValid), 256'd1);
      check(compFlag == VEC_FLAG[v], $sformatf("R2 R7 code vec %0d", v),
            256'(compFlag), 256'(VEC_FLAG[v]));
      check(compSize == VEC_SIZE[v], $sformatf("R2 size vec %0d", v),
            256'(compSize), 256'(VEC_SIZE[v]));
      rebuild();
      check(outValid == 1'b0, "R1 outValid single pulse", 256'(outValid), 256'd0);
      check(decOutValid == 1'b1, "R1 decOutValid", 256'(decOutValid), 256'd1);
      check(decLine == VEC_LINE[v], $sformatf("R9 round trip vec %0d", v),
            decLine, VEC_LINE[v]);
    end

    // R3: zero line form
    compress(VEC_LINE[0]);
    check(compData == '0 && baseSel == '0, "R3 zero packed", compData, '0);

    // R4: repeated value sits in bytes 0..7
    compress(VEC_LINE[1]);
    check(compData == 256'h0123456789ABCDEF, "R4 repeat packed",
          compData, 256'h0123456789ABCDEF);

    // R5 R6: 4-byte base, 1-byte deltas, all elements against element 0
    compress(VEC_LINE[2]);
    check(compData == {160'h0, 64'h3830282018100800, 32'hC04039C0},
          "R6 base4 delta1 layout", compData,
          {160'h0, 64'h3830282018100800, 32'hC04039C0});
    check(baseSel == 16'h00FF, "R5 selectors first-element base",
          256'(baseSel), 256'h00FF);

    // R5 R6: mixed bases, including -128 from zero
    compress(VEC_LINE[5]);
    check(compData == {160'h0, 8'h80, 8'h03, 8'h05, 8'h00, 64'h1122334455667788},
          "R6 base8 delta1 layout", compData,
          {160'h0, 8'h80, 8'h03, 8'h05, 8'h00, 64'h1122334455667788});
    check(baseSel == 16'h0003, "R5 mixed selectors", 256'(baseSel), 256'h0003);

    // R5: narrow values prefer the zero base
    compress(VEC_LINE[3]);
    check(baseSel == 16'h0000, "R5 zero-base selectors", 256'(baseSel), 256'h0);

    // R7: tie between two 12-byte forms goes to the lower code
    compress(VEC_LINE[6]);
    check(compFlag == 4'd2, "R7 tie low code", 256'(compFlag), 256'd2);

    // R8: uncompressible line passes through
    compress(VEC_LINE[10]);
    check(compData == VEC_LINE[10] && baseSel == '0, "R8 raw passthrough",
          compData, VEC_LINE[10]);

    // R11: new data without inValid leaves the outputs alone
    compress(VEC_LINE[2]);
    @(negedge clk);
    lineIn = VEC_LINE[10];
    @(negedge clk);
    lineIn = VEC_LINE[0];
    @(negedge clk);
    check(compFlag == 4'd5 && compSize == 6'd12 && outValid == 1'b0,
          "R11 hold ctrl", {compFlag, compSize, outValid}, {4'd5, 6'd12, 1'b0});
    check(compData == {160'h0, 64'h3830282018100800, 32'hC04039C0},
          "R11 hold data", compData, {160'h0, 64'h3830282018100800, 32'hC04039C0});

    finish_run();
  end
endmodule